// File: doc/BRIEF.md
# Byte Shift and Rotate Unit with Status Flags

This unit takes one byte operand and applies one of eight shift or rotate operations to it, chosen by a 3-bit code. The low bit of the code gives the direction: even codes move bits toward the most significant end and odd codes move them toward the least significant end. The operation reads the incoming carry flag when it needs one. It returns the shifted byte and a new 8-bit status byte.

A start strobe captures the operand, the code, the incoming status byte and a form select. The short form is meant for the accumulator. It finishes in 4 cycles and rewrites only the carry, half-carry and subtract flags. The long form finishes in 8 cycles and also recomputes sign, zero, the two copied result bits and parity from the result. A single-cycle done pulse marks completion. Result and flags stay unchanged from then until the next completion.

Status byte layout: bit 7 sign, bit 6 zero, bit 5 copy of result bit 5, bit 4 half-carry, bit 3 copy of result bit 3, bit 2 parity, bit 1 subtract, bit 0 carry.

Top module: `shift_rotate_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first completion, `result`, `flags_out` and `done` are all zero.
- R2: Left codes. Code 0 (rotate) moves old bit 7 into bit 0. Code 2 moves the incoming carry (`flags_in` bit 0) into bit 0. Code 4 fills bit 0 with 0. Code 6 fills bit 0 with 1. In every case, bits 6..0 move up by one position.
- R3: Right codes. Code 1 (rotate) moves old bit 0 into bit 7. Code 3 moves the incoming carry into bit 7. Code 5 keeps old bit 7, which sign-extends the value. Code 7 fills bit 7 with 0. In every case, bits 7..1 move down by one position.
- R4: The carry flag (bit 0) becomes old bit 7 for even codes and old bit 0 for odd codes.
- R5: The half-carry flag (bit 4) and the subtract flag (bit 1) are always 0 at completion.
- R6: In short form (`fast`=1), flag bits 7, 6, 5, 3 and 2 are copies of the captured `flags_in` bits.
- R7: In long form, the flags are computed from the result as follows. Bit 7 is result bit 7. Bit 6 is 1 when the result is zero. Bits 5 and 3 copy result bits 5 and 3. Bit 2 is 1 when the result has an even number of ones.
- R8: When `start` is accepted at clock edge n, `done` is high for exactly one cycle, starting at edge n+4 in short form and at edge n+8 in long form. `result` and `flags_out` change at that same edge.
- R9: A `start` that arrives while an operation is in flight is ignored, up to and including the edge at which `done` rises. It changes neither the timing nor the outcome.
- R10: Between completions, `result` and `flags_out` hold their values.
- R11: The unit captures its inputs at the accepting edge. Later changes to `operand`, `op`, `fast` or `flags_in` do not affect the operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 3 | Operation code, 0..7 |
| fast | input | 1 | 1 = short accumulator form, 0 = long form |
| operand | input | 8 | Byte to shift |
| flags_in | input | 8 | Incoming status byte |
| result | output | 8 | Shifted byte |
| flags_out | output | 8 | Updated status byte |
| done | output | 1 | One-cycle completion pulse |

## Verification
A captured code or form that is wrong, or a countdown that goes wrong, shows at the ports when the next completion arrives. It appears as a bad byte, a bad flag, or a done pulse that comes early, late or twice. The reference model is compared against the ports on every cycle, so the first bad cycle is reported at most 8 cycles after the start that caused it. Starts issued mid-flight and inputs changed after capture make corrupted capture registers visible in the same way.

// File: rtl/srot_pkg.sv
package srot_pkg;

    typedef enum logic [2:0] {
        OP_RLC = 3'd0,
        OP_RRC = 3'd1,
        OP_RL  = 3'd2,
        OP_RR  = 3'd3,
        OP_SLA = 3'd4,
        OP_SRA = 3'd5,
        OP_SLL = 3'd6,
        OP_SRL = 3'd7
    } rot_op_e;

    localparam int FLG_C = 0;
    localparam int FLG_N = 1;
    localparam int FLG_P = 2;
    localparam int FLG_X = 3;
    localparam int FLG_H = 4;
    localparam int FLG_Y = 5;
    localparam int FLG_Z = 6;
    localparam int FLG_S = 7;
    localparam int FLG_W = 8;

endpackage

// File: rtl/srot_shifter.sv
module srot_shifter
    import srot_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] val_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);

    localparam int MSB = DATA_W - 1;

    logic to_left;
    logic fill_bit;

    always_comb begin
        to_left = ~op_i[0];
        unique case (rot_op_e'(op_i))
            OP_RLC:  fill_bit = val_i[MSB];
            OP_RRC:  fill_bit = val_i[0];
            OP_RL:   fill_bit = cin_i;
            OP_RR:   fill_bit = cin_i;
            OP_SLA:  fill_bit = 1'b0;
            OP_SRA:  fill_bit = val_i[MSB];
            OP_SLL:  fill_bit = 1'b1;
            OP_SRL:  fill_bit = 1'b0;
            default: fill_bit = 1'b0;
        endcase
        if (to_left) begin
            res_o  = {val_i[MSB-1:0], fill_bit};
            cout_o = val_i[MSB];
        end else begin
            res_o  = {fill_bit, val_i[MSB:1]};
            cout_o = val_i[0];
        end
    end

endmodule

// File: rtl/srot_flagger.sv
module srot_flagger
    import srot_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic              cout_i,
    input  logic              fast_i,
    input  logic [FLG_W-1:0]  flg_i,
    output logic [FLG_W-1:0]  flg_o
);

    logic [FLG_W-1:0] from_res;
    logic             par_even;

    always_comb begin
        par_even        = ~(^res_i);
        from_res        = '0;
        from_res[FLG_S] = res_i[DATA_W-1];
        from_res[FLG_Z] = (res_i == '0);
        from_res[FLG_Y] = res_i[5];
        from_res[FLG_X] = res_i[3];
        from_res[FLG_P] = par_even;

        flg_o = fast_i ? flg_i : from_res;
        flg_o[FLG_C] = cout_i;
        flg_o[FLG_H] = 1'b0;
        flg_o[FLG_N] = 1'b0;
    end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import srot_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int LAT_FAST = 4,
    parameter int LAT_FULL = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic              fast,
    input  logic [DATA_W-1:0] operand,
    input  logic [FLG_W-1:0]  flags_in,
    output logic [DATA_W-1:0] result,
    output logic [FLG_W-1:0]  flags_out,
    output logic              done
);

    localparam int LAT_MAX = (LAT_FULL > LAT_FAST) ? LAT_FULL : LAT_FAST;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);
    localparam logic [CNT_W-1:0] LOAD_FAST = CNT_W'(LAT_FAST - 1);
    localparam logic [CNT_W-1:0] LOAD_FULL = CNT_W'(LAT_FULL - 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [2:0]        op;
        logic              fast;
        logic [DATA_W-1:0] opnd;
        logic [FLG_W-1:0]  flg;
        logic [DATA_W-1:0] res;
        logic [FLG_W-1:0]  fout;
        logic              done;
    } srot_state_t;

    srot_state_t st_d, st_q;

    logic [DATA_W-1:0] sh_res;
    logic              sh_cout;
    logic [FLG_W-1:0]  fl_new;

    logic              busy_lat;
    logic [2:0]        op_lat;
    logic              fast_lat;
    logic [DATA_W-1:0] opnd_lat;
    logic [FLG_W-1:0]  flg_lat;

    srot_shifter #(.DATA_W(DATA_W)) u_shifter (
        .op_i   (st_q.op),
        .val_i  (st_q.opnd),
        .cin_i  (st_q.flg[FLG_C]),
        .res_o  (sh_res),
        .cout_o (sh_cout)
    );

    srot_flagger #(.DATA_W(DATA_W)) u_flagger (
        .res_i  (sh_res),
        .cout_i (sh_cout),
        .fast_i (st_q.fast),
        .flg_i  (st_q.flg),
        .flg_o  (fl_new)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.res  = sh_res;
                st_d.fout = fl_new;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = fast ? LOAD_FAST : LOAD_FULL;
            st_d.op   = op;
            st_d.fast = fast;
            st_d.opnd = operand;
            st_d.flg  = flags_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result    = st_q.res;
    assign flags_out = st_q.fout;
    assign done      = st_q.done;

    assign busy_lat = st_q.busy;
    assign op_lat   = st_q.op;
    assign fast_lat = st_q.fast;
    assign opnd_lat = st_q.opnd;
    assign flg_lat  = st_q.flg;

endmodule

// File: rtl/srot_chk.sv
module srot_chk
    import srot_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic [DATA_W-1:0] result,
    input logic [FLG_W-1:0]  flags_out,
    input logic              busy_lat,
    input logic [2:0]        op_lat,
    input logic              fast_lat,
    input logic [DATA_W-1:0] opnd_lat,
    input logic [FLG_W-1:0]  flg_lat
);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    hn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!flags_out[FLG_H] && !flags_out[FLG_N]));

    // R4
    carry_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flags_out[FLG_C] == (op_lat[0] ? opnd_lat[0] : opnd_lat[DATA_W-1])));

    // R6
    fast_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fast_lat) |-> (flags_out[FLG_S] == flg_lat[FLG_S] &&
                                flags_out[FLG_Z] == flg_lat[FLG_Z] &&
                                flags_out[FLG_Y] == flg_lat[FLG_Y] &&
                                flags_out[FLG_X] == flg_lat[FLG_X] &&
                                flags_out[FLG_P] == flg_lat[FLG_P]));

    // R7
    full_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fast_lat) |-> (flags_out[FLG_Z] == (result == '0)));

    // R10
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(flags_out)));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_lat && start) |=> $stable(opnd_lat));

endmodule

bind shift_rotate_unit srot_chk #(.DATA_W(DATA_W)) u_srot_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .result    (result),
    .flags_out (flags_out),
    .busy_lat  (busy_lat),
    .op_lat    (op_lat),
    .fast_lat  (fast_lat),
    .opnd_lat  (opnd_lat),
    .flg_lat   (flg_lat)
);

// File: tb/test_shift_rotate_unit.sv
module test_shift_rotate_unit;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [2:0] op;
    logic       fast;
    logic [7:0] operand;
    logic [7:0] flags_in;
    logic [7:0] result;
    logic [7:0] flags_out;
    logic       done;

    always #4 clk = ~clk;

    shift_rotate_unit i_shift_rotate_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (op),
        .fast      (fast),
        .operand   (operand),
        .flags_in  (flags_in),
        .result    (result),
        .flags_out (flags_out),
        .done      (done)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    live   = 1'b0;
    string cur_req = "R1";

    // behavioural reference model
    int         rem = 0;
    logic [7:0] m_res = 8'h00, m_flg = 8'h00, p_res = 8'h00, p_flg = 8'h00;
    logic       m_done = 1'b0;

    function automatic logic [15:0] ref_calc(int code, int v, int fin, bit shortf);
        int r, co, c, ones, fl;
        c = fin % 2;
        case (code)
            0: begin r = (v * 2) % 256 + v / 128;        co = v / 128; end
            1: begin r = v / 2 + (v % 2) * 128;          co = v % 2;   end
            2: begin r = (v * 2) % 256 + c;              co = v / 128; end
            3: begin r = v / 2 + c * 128;                co = v % 2;   end
            4: begin r = (v * 2) % 256;                  co = v / 128; end
            5: begin r = v / 2 + (v / 128) * 128;        co = v % 2;   end
            6: begin r = (v * 2) % 256 + 1;              co = v / 128; end
            default: begin r = v / 2;                    co = v % 2;   end
        endcase
        ones = 0;
        for (int k = 0; k < 8; k++) ones += (r >> k) % 2;
        if (shortf) begin
            fl = fin & 8'hEC; // keep bits 7,6,5,3,2
        end else begin
            fl = (r / 128) * 128 + ((r == 0) ? 64 : 0) + ((r / 32) % 2) * 32 +
                 ((r / 8) % 2) * 8 + ((ones % 2 == 0) ? 4 : 0);
        end
        fl = fl + co;
        return {8'(r), 8'(fl)};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            rem = 0; m_res = 0; m_flg = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (rem > 0) begin
                rem--;
                if (rem == 0) begin
                    m_done = 1; m_res = p_res; m_flg = p_flg;
                end
            end else if (start) begin
                rem = fast ? 4 : 8;
                {p_res, p_flg} = ref_calc(int'(op), int'(operand), int'(flags_in), fast);
            end
        end
    end

    task automatic check(string req, logic [16:0] act, logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {done,result,flags} actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (live) check(cur_req, {done, result, flags_out}, {m_done, m_res, m_flg});
    end

    task automatic issue(int code, int v, int fin, bit shortf);
        @(negedge clk);
        start = 1'b1; op = 3'(code); operand = 8'(v); flags_in = 8'(fin); fast = shortf;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int vals[6];
        vals = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'h5A, 8'hA5};
        rst_n = 1'b0; start = 1'b0; op = 3'd0; fast = 1'b0; operand = 8'h00; flags_in = 8'h00;
        idle(3);
        // R1: outputs zero in reset
        check("R1", {done, result, flags_out}, 17'h0);
        rst_n = 1'b1;
        live  = 1'b1;
        idle(3);

        // main sweep: every code, operands, carry in, both forms; per-clock compare covers timing
        for (int code = 0; code < 8; code++) begin
            for (int vi = 0; vi < 6; vi++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    for (int fi = 0; fi < 2; fi++) begin
                        if (code % 2 == 0) cur_req = (fi != 0) ? "R2,R4,R5,R6,R8,R10" : "R2,R4,R5,R7,R8,R10";
                        else               cur_req = (fi != 0) ? "R3,R4,R5,R6,R8,R10" : "R3,R4,R5,R7,R8,R10";
                        issue(code, vals[vi], (ci != 0) ? 8'hED : 8'h12, fi != 0);
                        idle((fi != 0) ? 5 : 9);
                    end
                end
            end
        end

        // R9: starts during flight, including on the done edge
        cur_req = "R9";
        issue(6, 8'h3C, 8'h00, 1'b0);
        @(negedge clk); start = 1'b1; op = 3'd7; operand = 8'hF0;
        @(negedge clk); start = 1'b0;
        idle(3);
        start = 1'b1; @(negedge clk); start = 1'b0; // lands near the done edge
        idle(12);
        cur_req = "R9";
        issue(1, 8'h81, 8'hFF, 1'b1);
        @(negedge clk); start = 1'b1; op = 3'd4; fast = 1'b0; operand = 8'h7E;
        idle(4); start = 1'b0;
        idle(12);

        // R11: inputs change after capture
        cur_req = "R11";
        issue(3, 8'h55, 8'h01, 1'b0);
        operand = 8'hAA; op = 3'd0; flags_in = 8'h00; fast = 1'b1;
        idle(10);
        cur_req = "R11";
        issue(5, 8'h90, 8'hFF, 1'b1);
        operand = 8'h01; flags_in = 8'h00; fast = 1'b0;
        idle(6);

        // R10: long idle, outputs must stay put
        cur_req = "R10";
        idle(20);

        // R1: reset mid-flight clears everything
        cur_req = "R1";
        issue(0, 8'hC3, 8'h00, 1'b0);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(10);

        live = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule